// File: doc/BRIEF.md
# Video Control Pulse Filter

This block conditions the three single-bit video timing controls (data enable, horizontal sync and vertical sync) in the pixel clock domain, before a later stage carries them across a serial link. It removes pulses that are too short and keeps each lane inside a transition budget. When a qualified edge is accepted, it appears on the output after a fixed delay. When an edge would break the budget, the output holds its level and the lane's violation flag pulses.

A 2-bit filter mode selects, for the enable and horizontal sync lanes only, whether a minimum pulse width is enforced. The vertical sync lane always uses the width filter and has a tighter budget, and the mode has no effect on it. An edge-select input decides whether the inputs are sampled on the rising or on the falling pixel clock edge. Both choices give the same output timing.

Top module: `vid_ctl_filter`

## Requirements
- R1: While `rst_n` is low, and directly after it is released, all three outputs and all three bits of `rate_err` are 0.
- R2: With `filt_mode` = 00, the enable and horizontal sync lanes pass every pulse, including a pulse that is only one clock long.
- R3: With `filt_mode` = 01, a pulse shorter than 3 clocks on the enable or horizontal sync lane is suppressed and the output keeps its level. A pulse of 3 clocks or more passes.
- R4: `filt_mode` values 10 and 11 behave exactly like 00.
- R5: The vertical sync lane always suppresses pulses shorter than 3 clocks, whatever `filt_mode` is.
- R6: An accepted transition reaches its output on the third rising edge after the rising edge that first takes the new level into the block. This latency is the same in every mode.
- R7: The enable and horizontal sync lanes each accept at most 2 output transitions in any 130-clock window. A transition that would be the third is dropped, the output holds, and the lane's `rate_err` bit (bit 0 enable, bit 1 horizontal sync) is 1 for exactly one clock, in the cycle where the transition would have appeared. A third transition exactly 130 clocks after the oldest accepted one is accepted.
- R8: The vertical sync lane accepts at most 1 transition per 130 clocks. An earlier one is dropped with `rate_err[2]` high for one clock.
- R9: With `edge_rise` = 1 the inputs are sampled on the rising clock edge. With `edge_rise` = 0 they are sampled on the falling edge. A level that is present only around a falling edge is seen only when `edge_rise` = 0.
- R10: After a dropped transition, an input that returns to the level the output still holds raises no flag and uses none of the budget.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| filt_mode | input | 2 | 01 enables the width filter on enable/hsync; 00, 10 and 11 disable it |
| edge_rise | input | 1 | 1 samples on the rising edge, 0 on the falling edge |
| de_in | input | 1 | Data enable input |
| hs_in | input | 1 | Horizontal sync input |
| vs_in | input | 1 | Vertical sync input |
| de_out | output | 1 | Filtered data enable |
| hs_out | output | 1 | Filtered horizontal sync |
| vs_out | output | 1 | Filtered vertical sync |
| rate_err | output | 3 | One-clock violation flags, bit 0 enable, bit 1 hsync, bit 2 vsync |

## Verification
Stimulus is applied just after a rising edge p. An accepted level therefore appears on the outputs at edge p+4: one edge to sample the input and three more through the qualifier and budget stages. A dropped transition raises its flag at that same edge p+4 and clears it at p+5. The stimulus table checks the outputs both at p+3, where the old level is still expected, and at p+4. The directed tests use the same rule for short pulses, for the flag cycle, and for budget edges placed 129 and 130 clocks after the oldest accepted transition. The falling-edge case drives a half-cycle pulse that covers only a falling edge, and its result is still due at p+4.

// File: rtl/vid_ctl_pkg.sv
package vid_ctl_pkg;

  localparam int unsigned NUM_LANES = 3;
  localparam int unsigned LANE_DE   = 0;
  localparam int unsigned LANE_HS   = 1;
  localparam int unsigned LANE_VS   = 2;

  typedef enum logic [1:0] {
    FMODE_OPEN = 2'b00,
    FMODE_MINW = 2'b01,
    FMODE_ALTA = 2'b10,
    FMODE_ALTB = 2'b11
  } fmode_e;

  // Only the min-width code arms the filter; the other codes pass pulses through.
  function automatic logic fmode_filters(input logic [1:0] m);
    return (m == FMODE_MINW);
  endfunction

endpackage

// File: rtl/vcl_edge_capture.sv
// Samples the raw lanes on either clock edge; the falling-edge copy is
// retimed so that both choices present a level at the same rising edge.
module vcl_edge_capture #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         edge_rise,
  input  logic [W-1:0] raw,
  output logic [W-1:0] smp
);

  logic [W-1:0] rise_q;
  logic [W-1:0] fall_q;
  logic [W-1:0] fall_rt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rise_q <= '0;
    else        rise_q <= raw;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= '0;
    else        fall_q <= raw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fall_rt_q <= '0;
    else        fall_rt_q <= fall_q;
  end

  assign smp = edge_rise ? rise_q : fall_rt_q;

endmodule

// File: rtl/vcl_pulse_qualifier.sv
// Keeps MIN_W samples of one lane; with the filter on, a level is offered
// only once every sample in the window agrees.
module vcl_pulse_qualifier #(
  parameter int unsigned MIN_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic filt_on,
  input  logic smp,
  output logic lvl_vld,
  output logic lvl
);

  localparam int unsigned HD = MIN_W - 1;

  logic [HD-1:0]    hist_q;
  logic [HD-1:0]    hist_d;
  logic [MIN_W-1:0] win;
  logic             stable;

  always_comb begin
    win    = {hist_q, smp};
    hist_d = win[MIN_W-2:0];
    stable = (&win) | (~|win);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  assign lvl     = win[MIN_W-1];
  assign lvl_vld = filt_on ? stable : 1'b1;

endmodule

// File: rtl/vcl_rate_guard.sv
// Per-lane budget: remembers the ages of the last BUDGET accepted edges and
// drops a new edge while the oldest of them is younger than WIN clocks.
module vcl_rate_guard #(
  parameter int unsigned WIN    = 130,
  parameter int unsigned BUDGET = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_vld,
  input  logic lvl,
  output logic lane_out,
  output logic lane_err
);

  localparam int unsigned    AGE_W   = (WIN > 2) ? $clog2(WIN) : 1;
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(WIN - 1);

  logic ref_q, ref_d;
  logic out_q, out_d;
  logic err_q, err_d;
  logic cand, moves, room, take;

  logic [BUDGET-1:0]            vld_q, vld_d;
  logic [BUDGET-1:0][AGE_W-1:0] age_q, age_d, aged;

  always_comb begin
    cand  = lvl_vld && (lvl != ref_q);
    moves = cand && (lvl != out_q);
    room  = !vld_q[BUDGET-1] || (age_q[BUDGET-1] >= AGE_MAX);
    take  = moves && room;
    ref_d = cand ? lvl : ref_q;
    out_d = take ? lvl : out_q;
    err_d = moves && !room;
  end

  for (genvar s = 0; s < BUDGET; s++) begin : g_age
    assign aged[s] = (age_q[s] == AGE_MAX) ? age_q[s] : age_q[s] + 1'b1;
  end

  assign vld_d[0] = take ? 1'b1 : vld_q[0];
  assign age_d[0] = take ? '0   : aged[0];

  for (genvar s = 1; s < BUDGET; s++) begin : g_slot
    assign vld_d[s] = take ? vld_q[s-1] : vld_q[s];
    assign age_d[s] = take ? aged[s-1]  : aged[s];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= 1'b0;
      out_q <= 1'b0;
      err_q <= 1'b0;
      vld_q <= '0;
      age_q <= '0;
    end else begin
      ref_q <= ref_d;
      out_q <= out_d;
      err_q <= err_d;
      vld_q <= vld_d;
      age_q <= age_d;
    end
  end

  assign lane_out = out_q;
  assign lane_err = err_q;

endmodule

// File: rtl/vid_ctl_filter.sv
module vid_ctl_filter
  import vid_ctl_pkg::*;
#(
  parameter int unsigned WIN         = 130,
  parameter int unsigned MIN_W       = 3,
  parameter int unsigned FAST_BUDGET = 2,
  parameter int unsigned SLOW_BUDGET = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] filt_mode,
  input  logic       edge_rise,
  input  logic       de_in,
  input  logic       hs_in,
  input  logic       vs_in,
  output logic       de_out,
  output logic       hs_out,
  output logic       vs_out,
  output logic [2:0] rate_err
);

  logic [NUM_LANES-1:0] raw, smp, filt_on, lvl_vld, lvl, lane_q, rate_q;

  assign raw = {vs_in, hs_in, de_in};

  vcl_edge_capture #(.W(NUM_LANES)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .edge_rise (edge_rise),
    .raw       (raw),
    .smp       (smp)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam bit          IS_VS = (g == LANE_VS);
    localparam int unsigned BUD   = IS_VS ? SLOW_BUDGET : FAST_BUDGET;

    assign filt_on[g] = IS_VS ? 1'b1 : fmode_filters(filt_mode);

    vcl_pulse_qualifier #(.MIN_W(MIN_W)) u_qual (
      .clk     (clk),
      .rst_n   (rst_n),
      .filt_on (filt_on[g]),
      .smp     (smp[g]),
      .lvl_vld (lvl_vld[g]),
      .lvl     (lvl[g])
    );

    vcl_rate_guard #(.WIN(WIN), .BUDGET(BUD)) u_guard (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl_vld  (lvl_vld[g]),
      .lvl      (lvl[g]),
      .lane_out (lane_q[g]),
      .lane_err (rate_q[g])
    );
  end

  assign {vs_out, hs_out, de_out} = lane_q;
  assign rate_err = rate_q;

endmodule

// File: rtl/vid_ctl_filter_chk.sv
module vid_ctl_filter_chk
  import vid_ctl_pkg::*;
#(
  parameter int unsigned WIN   = 130,
  parameter int unsigned LANES = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LANES-1:0] lane_q,
  input logic [LANES-1:0] err_q,
  input logic [LANES-1:0] lvl_vld,
  input logic [LANES-1:0] lvl
);

  localparam int unsigned      AW   = (WIN > 2) ? $clog2(WIN) : 1;
  localparam logic [AW-1:0]    AMAX = AW'(WIN - 1);

  logic [LANES-1:0]         prev_q;
  logic [LANES-1:0][AW-1:0] age1_q, age2_q;
  logic [LANES-1:0][1:0]    seen_q;
  logic [LANES-1:0]         moved;

  assign moved = lane_q ^ prev_q;

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    logic [AW-1:0] inc1, inc2;
    assign inc1 = (age1_q[i] == AMAX) ? age1_q[i] : age1_q[i] + 1'b1;
    assign inc2 = (age2_q[i] == AMAX) ? age2_q[i] : age2_q[i] + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q[i] <= 1'b0;
        age1_q[i] <= '0;
        age2_q[i] <= '0;
        seen_q[i] <= '0;
      end else begin
        prev_q[i] <= lane_q[i];
        if (moved[i]) begin
          age1_q[i] <= '0;
          age2_q[i] <= inc1;
          seen_q[i] <= (seen_q[i] == 2'd2) ? 2'd2 : seen_q[i] + 2'd1;
        end else begin
          age1_q[i] <= inc1;
          age2_q[i] <= inc2;
        end
      end
    end

    // R7 and R8: a violation flag lasts one clock
    p_err_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      err_q[i] |=> !err_q[i]);

    // R7 and R8: a dropped edge leaves the output untouched
    p_err_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      err_q[i] |-> $stable(lane_q[i]));

    // R6: an output move follows a qualified level offered one clock earlier
    p_move_from_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
      moved[i] |-> ($past(lvl_vld[i]) && ($past(lvl[i]) == lane_q[i])));

    if (i == LANE_VS) begin : g_slow
      p_slow_budget_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (moved[i] && (seen_q[i] != 2'd0)) |-> (age1_q[i] >= AMAX));
    end else begin : g_fast
      p_fast_budget_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (moved[i] && (seen_q[i] == 2'd2)) |-> (age2_q[i] >= AMAX));
    end
  end

endmodule

bind vid_ctl_filter vid_ctl_filter_chk #(.WIN(WIN), .LANES(NUM_LANES)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .lane_q  (lane_q),
  .err_q   (rate_q),
  .lvl_vld (lvl_vld),
  .lvl     (lvl)
);

// File: tb/vid_ctl_filter_tb_top.sv
module vid_ctl_filter_tb_top;

  localparam int HOLD = 135;
  localparam int NVEC = 8;
  // {mode[1:0], edge_rise, stim{vs,hs,de}, expected{vs,hs,de}}
  localparam logic [8:0] VEC [NVEC] = '{
    9'b00_1_001_001, 9'b01_1_011_011, 9'b10_0_110_110, 9'b11_0_100_100,
    9'b01_0_101_101, 9'b00_1_010_010, 9'b01_1_000_000, 9'b11_1_111_111
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n;
  logic [1:0] mode;
  logic       esel, de, hs, vs;
  logic       de_o, hs_o, vs_o;
  logic [2:0] err;
  int         checks = 0;
  int         fails  = 0;
  bit         done   = 1'b0;

  vid_ctl_filter dut_i (
    .clk(clk), .rst_n(rst_n), .filt_mode(mode), .edge_rise(esel),
    .de_in(de), .hs_in(hs), .vs_in(vs),
    .de_out(de_o), .hs_out(hs_o), .vs_out(vs_o), .rate_err(err)
  );

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all-reqs actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [2:0] prev;
    rst_n = 1'b0; mode = 2'b00; esel = 1'b1; de = 0; hs = 0; vs = 0;
    step(3);
    chk("R1 outputs in reset", {vs_o, hs_o, de_o}, 0);
    chk("R1 flags in reset", err, 0);
    rst_n = 1'b1;
    step(2);
    chk("R1 outputs after release", {vs_o, hs_o, de_o}, 0);

    // stimulus table: long levels, checked one clock early and on time
    prev = 3'b000;
    for (int i = 0; i < NVEC; i++) begin
      mode = VEC[i][8:7]; esel = VEC[i][6]; {vs, hs, de} = VEC[i][5:3];
      step(3);
      chk("R6 table old level at p+3", {vs_o, hs_o, de_o}, prev);
      step(1);
      chk("R6 R2 R4 table new level at p+4", {vs_o, hs_o, de_o}, VEC[i][2:0]);
      chk("R7 table no flag", err, 0);
      prev = VEC[i][2:0];
      step(HOLD - 4);
    end

    // reset from a non-zero state
    rst_n = 1'b0; de = 0; hs = 0; vs = 0; mode = 2'b00; esel = 1'b1;
    #1;
    chk("R1 outputs cleared by reset", {vs_o, hs_o, de_o}, 0);
    step(2);
    rst_n = 1'b1;
    step(2);

    // R3: 2-clock pulse suppressed, 3-clock pulse passes
    mode = 2'b01;
    de = 1; step(2); de = 0;
    for (int k = 0; k < 6; k++) begin step(1); chk("R3 short de pulse held", de_o, 0); end
    chk("R3 no flag on short pulse", err, 0);
    hs = 1; step(3); hs = 0;
    step(1); chk("R3 3-clock hs pulse rises", hs_o, 1);
    step(2); chk("R3 3-clock hs pulse still high", hs_o, 1);
    step(1); chk("R3 3-clock hs pulse falls", hs_o, 0);
    step(140);

    // R2, R4: 1-clock pulses pass with filter off
    mode = 2'b00;
    de = 1; step(1); de = 0;
    step(3); chk("R2 1-clock de pulse rises", de_o, 1);
    step(1); chk("R2 1-clock de pulse falls", de_o, 0);
    mode = 2'b11;
    hs = 1; step(1); hs = 0;
    step(3); chk("R4 mode 11 1-clock hs rises", hs_o, 1);
    step(1); chk("R4 mode 11 1-clock hs falls", hs_o, 0);
    step(140);

    // R5: vsync width filter regardless of mode
    mode = 2'b00;
    vs = 1; step(2); vs = 0;
    for (int k = 0; k < 6; k++) begin step(1); chk("R5 short vs pulse held", vs_o, 0); end
    step(10);

    // R8, R10: vsync budget
    vs = 1;
    step(4); chk("R8 first vs edge", vs_o, 1); chk("R8 no flag first edge", err, 0);
    step(46); vs = 0;
    step(4); chk("R8 early vs edge dropped", vs_o, 1); chk("R8 vs flag", err, 3'b100);
    step(1); chk("R8 vs flag one clock", err, 0);
    step(5); vs = 1;
    step(4); chk("R10 return to held level no flag", err, 0); chk("R10 vs holds", vs_o, 1);
    step(140); vs = 0;
    step(4); chk("R8 vs edge after window", vs_o, 0); chk("R8 no flag after window", err, 0);
    step(140);

    // R7: third de edge inside window dropped
    de = 1; step(10); de = 0; step(10); de = 1;
    step(4); chk("R7 third de edge dropped", de_o, 0); chk("R7 de flag", err, 3'b001);
    step(1); chk("R7 de flag one clock", err, 0);
    de = 0;
    step(140);

    // R7 boundary: third edge exactly 130 clocks after the oldest accepted
    de = 1; step(1); de = 0;
    step(129); de = 1;
    step(4); chk("R7 de edge at 130 accepted", de_o, 1); chk("R7 no flag at 130", err, 0);

    // R7 boundary: 129 clocks dropped, R10 recovery
    hs = 1; step(1); hs = 0;
    step(128); hs = 1;
    step(4); chk("R7 hs edge at 129 dropped", hs_o, 0); chk("R7 hs flag", err, 3'b010);
    step(1); chk("R7 hs flag one clock", err, 0);
    hs = 0; step(1); hs = 1;
    step(3); chk("R10 hs return no flag", err, 0);
    step(1); chk("R7 hs edge after window", hs_o, 1); chk("R7 no flag late hs", err, 0);

    // R9: half-cycle glitch over a falling edge
    step(140); de = 0; hs = 0;
    step(4); chk("R9 de cleared before glitch test", de_o, 0);
    step(140);
    mode = 2'b00; esel = 1'b0;
    de = 1; #2; de = 0;
    step(4); chk("R9 falling-edge sample sees glitch", de_o, 1);
    step(1); chk("R9 glitch ends", de_o, 0);
    step(140);
    esel = 1'b1;
    de = 1; #2; de = 0;
    step(4); chk("R9 rising-edge sample misses glitch", de_o, 0);
    step(1); chk("R9 rising-edge still low", de_o, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule